// File: doc/BRIEF.md
# Split Decade Counter with Preset-to-Nine

The block is a 4-bit counter made of two sections, each advanced by its own count input. The low section divides by two and drives Q0. The high section divides by five and drives Q3..Q1, with Q3 as its divide-by-five output. A falling edge on a count input advances its section. The count inputs are brought into the system clock domain, and their falling edges become single-cycle enables. A mode select decides how the two sections are chained inside the block, so no external wiring is needed. In 8421 decade mode, the low section feeds the high section. In bi-quinary mode, the high section feeds the low section, and Q0 becomes a symmetrical square wave at one tenth of the input rate. In split mode, the two sections count separately.

Two gated overrides act directly on the state registers, without waiting for a clock edge. A clear zeroes the count and a preset loads nine. Each override takes effect only when both of its inputs are high. The preset wins over the clear.

Top module: `split_decade_counter`

## Requirements
- R1: While rst_ni is low, q_o reads 0000.
- R2: The high section steps through Q3..Q1 = 000, 001, 010, 011, 100 and then back to 000, so q_o never exceeds 9. The low section toggles Q0 on each step.
- R3: When clr_a_i and clr_b_i are both high and the preset is inactive, q_o becomes 0000 at once, with no clock edge needed. Either clear input alone has no effect.
- R4: When pre_a_i and pre_b_i are both high, q_o becomes 1001 at once, even if the clear is also active. Either preset input alone has no effect.
- R5: Mode 00 is 8421 decade mode. Each falling edge on cnt_lo_i moves q_o one step through 0 to 9, wrapping to 0. The high section advances one clock after Q0 falls. cnt_hi_i is ignored.
- R6: Mode 01 is bi-quinary mode. Each falling edge on cnt_hi_i advances the high section, and Q0 toggles one clock after Q3 falls. Over ten input edges Q0 is high for five and low for five. cnt_lo_i is ignored.
- R7: Modes 10 and 11 are split mode. cnt_lo_i toggles Q0 only, and cnt_hi_i advances Q3..Q1 only.
- R8: Only falling edges count; a rising edge or a steady level changes nothing. A falling edge that is set up before a rising clock edge shows on q_o after the third rising clock edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_lo_i | input | 1 | Count input of the divide-by-two section |
| cnt_hi_i | input | 1 | Count input of the divide-by-five section |
| mode_i | input | 2 | 00 decade, 01 bi-quinary, 10/11 split |
| clr_a_i | input | 1 | Clear gate input A |
| clr_b_i | input | 1 | Clear gate input B |
| pre_a_i | input | 1 | Preset-to-nine gate input A |
| pre_b_i | input | 1 | Preset-to-nine gate input B |
| q_o | output | 4 | Counter state Q3..Q0 |

## Verification
The bench applies random sequences of count pulses to both inputs under every mode code, mixed with mode changes and override pulses. Pulses sent to the input that a given mode ignores show whether the chaining is picked correctly. Runs of ten pulses in decade and bi-quinary mode distinguish the 8421 order from the square-wave order on Q0. Directed cases separate one-sided overrides from gated ones, check the priority of preset over clear, place a pulse high level mid-pulse to confirm that rising edges do not count, and count the exact clock latency of a falling edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    MODE_BCD   = 2'b00,
    MODE_BIQ   = 2'b01,
    MODE_SPLIT = 2'b10,
    MODE_SPARE = 2'b11
  } sdc_mode_e;

  localparam int unsigned LO_MOD     = 2;
  localparam int unsigned HI_MOD     = 5;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/sdc_fall_det.sv
module sdc_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= din_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sdc_div_stage.sv
module sdc_div_stage #(
  parameter int unsigned MODULUS    = 5,
  parameter int unsigned W          = $clog2(MODULUS),
  parameter logic [W-1:0] PRESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         pre_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         msb_fall_o
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic [W-1:0] cnt_q;
  logic         msb_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clr_i or posedge pre_i) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      msb_prev_q <= 1'b0;
    end else if (pre_i) begin
      cnt_q      <= PRESET_VAL;
      msb_prev_q <= PRESET_VAL[W-1];
    end else if (clr_i) begin
      cnt_q      <= '0;
      msb_prev_q <= 1'b0;
    end else begin
      msb_prev_q <= cnt_q[W-1];
      if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + W'(1);
    end
  end

  assign cnt_o      = cnt_q;
  assign msb_fall_o = msb_prev_q & ~cnt_q[W-1];
endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import sdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_lo_i,
  input  logic       cnt_hi_i,
  input  logic [1:0] mode_i,
  input  logic       clr_a_i,
  input  logic       clr_b_i,
  input  logic       pre_a_i,
  input  logic       pre_b_i,
  output logic [3:0] q_o
);
  localparam int unsigned LO_W = $clog2(LO_MOD);
  localparam int unsigned HI_W = $clog2(HI_MOD);

  sdc_mode_e mode;
  logic clr_w, pre_w;
  logic lo_fall, hi_fall;
  logic lo_step, hi_step;
  logic lo_msb_fall, hi_msb_fall;
  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;

  assign mode  = sdc_mode_e'(mode_i);
  assign clr_w = clr_a_i & clr_b_i;
  assign pre_w = pre_a_i & pre_b_i;

  sdc_fall_det #(.STAGES(SYNC_DEPTH)) u_lo_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(cnt_lo_i), .fall_o(lo_fall));
  sdc_fall_det #(.STAGES(SYNC_DEPTH)) u_hi_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(cnt_hi_i), .fall_o(hi_fall));

  // chaining picked by mode; spare code acts as split
  always_comb begin
    unique case (mode)
      MODE_BCD: begin
        lo_step = lo_fall;
        hi_step = lo_msb_fall;
      end
      MODE_BIQ: begin
        lo_step = hi_msb_fall;
        hi_step = hi_fall;
      end
      default: begin
        lo_step = lo_fall;
        hi_step = hi_fall;
      end
    endcase
  end

  sdc_div_stage #(.MODULUS(LO_MOD), .W(LO_W), .PRESET_VAL(LO_W'(1))) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .pre_i(pre_w),
    .step_i(lo_step), .cnt_o(lo_cnt), .msb_fall_o(lo_msb_fall));

  sdc_div_stage #(.MODULUS(HI_MOD), .W(HI_W), .PRESET_VAL(HI_W'(4))) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_w), .pre_i(pre_w),
    .step_i(hi_step), .cnt_o(hi_cnt), .msb_fall_o(hi_msb_fall));

  assign q_o = {hi_cnt, lo_cnt};
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       clr_a_i,
  input logic       clr_b_i,
  input logic       pre_a_i,
  input logic       pre_b_i,
  input logic [3:0] q_o
);
  logic force_w;
  assign force_w = (clr_a_i & clr_b_i) | (pre_a_i & pre_b_i);

  AST_RANGE_MAX_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o <= 4'd9); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && clr_b_i && !(pre_a_i && pre_b_i)) |-> q_o == 4'd0); // R3

  AST_PRESET_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_a_i && pre_b_i) |-> q_o == 4'd9); // R4

  AST_BCD_HI_WAITS_Q0: assert property (@(posedge clk_i) disable iff (!rst_ni || force_w)
    (mode_i == MODE_BCD && $past(mode_i) == MODE_BCD && !$past(force_w)
     && !($past(q_o[0], 2) && !$past(q_o[0])))
    |-> $stable(q_o[3:1])); // R5

  AST_BIQ_LO_WAITS_Q3: assert property (@(posedge clk_i) disable iff (!rst_ni || force_w)
    (mode_i == MODE_BIQ && $past(mode_i) == MODE_BIQ && !$past(force_w)
     && !($past(q_o[3], 2) && !$past(q_o[3])))
    |-> $stable(q_o[0])); // R6
endmodule

bind split_decade_counter sdc_checker u_sdc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .clr_a_i(clr_a_i), .clr_b_i(clr_b_i), .pre_a_i(pre_a_i), .pre_b_i(pre_b_i),
  .q_o(q_o));

// File: tb/split_decade_counter_tb_top.sv
module split_decade_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_lo = 1'b0, cnt_hi = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       clr_a = 1'b0, clr_b = 1'b0, pre_a = 1'b0, pre_b = 1'b0;
  logic [3:0] q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] model = 4'd0;

  always #5 clk = ~clk;

  split_decade_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
    .mode_i(mode), .clr_a_i(clr_a), .clr_b_i(clr_b), .pre_a_i(pre_a),
    .pre_b_i(pre_b), .q_o(q));

  function automatic logic [2:0] inc5(input logic [2:0] f);
    return (f == 3'd4) ? 3'd0 : f + 3'd1;
  endfunction

  function automatic logic [3:0] after_lo(input logic [3:0] s, input logic [1:0] m);
    logic [2:0] f = s[3:1];
    if (m == 2'b01) return s;
    if (m == 2'b00 && s[0]) f = inc5(f);
    return {f, ~s[0]};
  endfunction

  function automatic logic [3:0] after_hi(input logic [3:0] s, input logic [1:0] m);
    logic q0 = s[0];
    if (m == 2'b00) return s;
    if (m == 2'b01 && s[3:1] == 3'd4) q0 = ~q0;
    return {inc5(s[3:1]), q0};
  endfunction

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input bit hi_side, input string req);
    @(negedge clk);
    if (hi_side) cnt_hi = 1'b1; else cnt_lo = 1'b1;
    repeat (4) @(negedge clk);
    check(q, model, "R8 rising edge ignored");
    if (hi_side) cnt_hi = 1'b0; else cnt_lo = 1'b0;
    repeat (5) @(negedge clk);
    model = hi_side ? after_hi(model, mode) : after_lo(model, mode);
    check(q, model, req);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_a = 1'b1; clr_b = 1'b1;
    #1 model = 4'd0;
    check(q, model, "R3 gated clear async");
    repeat (2) @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (2) @(negedge clk);
    check(q, model, "R3 after clear release");
  endtask

  task automatic do_preset();
    @(negedge clk);
    pre_a = 1'b1; pre_b = 1'b1;
    #1 model = 4'd9;
    check(q, model, "R4 gated preset async");
    repeat (2) @(negedge clk);
    pre_a = 1'b0; pre_b = 1'b0;
    repeat (2) @(negedge clk);
    check(q, model, "R4 after preset release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int q0_high;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(q, 4'd0, "R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(q, 4'd0, "R1 after reset release");

    // R5 full decade run
    mode = 2'b00;
    for (int i = 0; i < 10; i++) pulse(1'b0, "R5 decade step");
    check(q, 4'd0, "R5 decade wrap");
    pulse(1'b1, "R5 hi input ignored");

    // R8 exact latency
    @(negedge clk); cnt_lo = 1'b1;
    repeat (4) @(negedge clk);
    cnt_lo = 1'b0;
    repeat (2) @(negedge clk);
    check(q, model, "R8 no change after two edges");
    @(negedge clk);
    model = after_lo(model, mode);
    check(q, model, "R8 change after third edge");
    repeat (3) @(negedge clk);

    // R6 bi-quinary square wave
    do_clear();
    mode = 2'b01;
    q0_high = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1'b1, "R6 biquinary step");
      if (q[0]) q0_high++;
    end
    checks++;
    if (q0_high != 5) begin
      errors++;
      $display("FAIL R6 square wave: q0 high %0d expected 5", q0_high);
    end
    pulse(1'b0, "R6 lo input ignored");

    // R7 split, both codes
    mode = 2'b10;
    for (int i = 0; i < 6; i++) pulse(1'b1, "R7 split hi / R2 wrap");
    pulse(1'b0, "R7 split lo");
    mode = 2'b11;
    pulse(1'b0, "R7 spare code lo");
    pulse(1'b1, "R7 spare code hi");

    // R3/R4 gating and priority
    do_preset();
    @(negedge clk); clr_a = 1'b1;
    repeat (2) @(negedge clk);
    check(q, model, "R3 single clear input ignored");
    clr_a = 1'b0; clr_b = 1'b1;
    repeat (2) @(negedge clk);
    check(q, model, "R3 single clear input ignored");
    clr_b = 1'b0;
    do_clear();
    @(negedge clk); pre_b = 1'b1;
    repeat (2) @(negedge clk);
    check(q, model, "R4 single preset input ignored");
    pre_b = 1'b0;
    @(negedge clk); clr_a = 1'b1; clr_b = 1'b1; pre_a = 1'b1; pre_b = 1'b1;
    #1 model = 4'd9;
    check(q, model, "R4 preset over clear");
    @(negedge clk); pre_a = 1'b0; pre_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
    repeat (2) @(negedge clk);
    check(q, model, "R4 held nine after release");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom_range(99));
      if (r < 40) pulse(1'b0, "R5/R6/R7 random lo");
      else if (r < 80) pulse(1'b1, "R5/R6/R7 random hi");
      else if (r < 90) begin
        @(negedge clk); mode = 2'($urandom_range(3));
      end
      else if (r < 95) do_clear();
      else do_preset();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule